// File: doc/BRIEF.md
# Keyed Calibration Register Interface

This block is the byte-wide host register window for a calibration subsystem on a paged register bus. When the bus points at the calibration page, four consecutive offsets give the host a data register, an address register, a command/status pair and a key/revision pair. Command writes start transfers on two transfer engines: a non-volatile calibration memory that can be read or written, and a bank of trim DACs that can only be written. The block talks to each engine through a request/done handshake. The serial protocols behind these engines are not part of this block.

Writes to the calibration memory are locked until the host writes an unlock key. The unlock holds for any number of transfers and is lost as soon as the bus leaves the calibration page. Two further key values turn an enhanced mode on and off. The off key also sends a one-cycle clear pulse to the enhanced logic elsewhere, which returns those registers and the acquisition FIFO depth to their defaults. The command register also drives the calibration-mux select and a reload strobe.

State machines. The transfer controller, used once per engine, has the states XF_IDLE and XF_WAIT. XF_IDLE goes to XF_WAIT on an accepted start. XF_WAIT goes back to XF_IDLE on done. The key tracker has the states KEY_LOCKED and KEY_OPEN. KEY_LOCKED goes to KEY_OPEN on an unlock-key write on the page. Any state goes to KEY_LOCKED when the page changes. The mode tracker has the states ENH_OFF and ENH_ON. ENH_OFF goes to ENH_ON on the on key. Any state goes to ENH_OFF on the off key, and that transition raises the clear pulse.

Top module: `cal_regif`

## Requirements
- R1: After reset, the data, address and status registers read 0x00, no request is active, the memory is locked and enhanced mode is off.
- R2: On the calibration page (3), a write to offset 12 loads the 8-bit data register and a write to offset 13 loads bits 6:0 of the address register. Bit 7 of the address register reads as 0. Writes made while another page is selected change nothing.
- R3: A command write (offset 14) with bit 0 set, made while unlocked and idle, raises `ee_req` on the next cycle. `ee_rnw` copies command bit 1 (0 = write, 1 = read). `ee_addr` carries the 7-bit address and `ee_wdata` the data register. Status bit 1 (memory busy) reads 1.
- R4: On `ee_done`, the request and status bit 1 drop on the same edge. For a read, the data register takes `ee_rdata` on that edge.
- R5: A memory start is ignored while locked or while a memory transfer is already running. Such a start raises no request, does not change the payload and does not set the busy flag.
- R6: Writing 0xA5 to offset 15 on the page unlocks the memory. The unlock holds across transfers and is cleared by any cycle with another page selected.
- R7: A command write with bit 4 set starts a trim-DAC write with `td_addr` = address bits 2:0 and `td_data` = the data register. Status bit 0 reads 1 until `td_done`. A start while busy is ignored. Status bit 4 shows the last written command bit 4.
- R8: Command bit 3 drives `calmux_en`, and status bit 3 reports it.
- R9: A command write with bit 2 set gives a single-cycle `cal_reload` pulse.
- R10: Writing 0xA6 to offset 15 sets `enh_mode`. Writing 0xA7 clears it and gives a single-cycle `enh_clear` pulse.
- R11: A read of offset 15 returns the revision parameter. A read of any other page or offset returns 0x00.
- R12: While a request is waiting for done, it stays high and its address, data and direction stay constant, even if the host rewrites the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_page | input | 3 | Currently selected register page |
| bus_ofs | input | 4 | Register offset within the page |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from page/offset) |
| ee_req | output | 1 | Memory transfer request, held until done |
| ee_rnw | output | 1 | Memory direction, 1 = read |
| ee_addr | output | 7 | Memory location |
| ee_wdata | output | 8 | Memory write byte |
| ee_done | input | 1 | Memory transfer complete pulse |
| ee_rdata | input | 8 | Memory read byte, valid with done |
| td_req | output | 1 | Trim-DAC write request, held until done |
| td_addr | output | 3 | Trim-DAC channel |
| td_data | output | 8 | Trim-DAC value |
| td_done | input | 1 | Trim-DAC write complete pulse |
| calmux_en | output | 1 | Calibration mux select |
| cal_reload | output | 1 | Reload-from-memory strobe |
| enh_mode | output | 1 | Enhanced mode active |
| enh_clear | output | 1 | Clear pulse for enhanced logic |

## Verification
On every cycle the assertions check four things: a pending request holds with a frozen payload, done retires the request, a memory request can only begin after the key was open, and leaving the page drops the unlock at the next edge. The off key must also never leave enhanced mode set while its clear pulse is out. Only the bench scenarios can show the register values the host sees. These cover the 7-bit address masking, read data captured at done, starts ignored while locked or busy, the width of the strobes and the revision value.

// File: rtl/cal_pkg.sv
package cal_pkg;
    typedef enum logic [0:0] {XF_IDLE, XF_WAIT} xfer_state_t;
    typedef enum logic [0:0] {KEY_LOCKED, KEY_OPEN} key_state_t;
    typedef enum logic [0:0] {ENH_OFF, ENH_ON} enh_state_t;

    localparam logic [7:0] KEY_UNLOCK  = 8'hA5;
    localparam logic [7:0] KEY_ENH_ON  = 8'hA6;
    localparam logic [7:0] KEY_ENH_OFF = 8'hA7;

    // command bit positions
    localparam int CB_EE_GO  = 0;
    localparam int CB_EE_RNW = 1;
    localparam int CB_RELOAD = 2;
    localparam int CB_CMUX   = 3;
    localparam int CB_TD_GO  = 4;

    // status bit positions
    localparam int SB_TD_BUSY = 0;
    localparam int SB_EE_BUSY = 1;
    localparam int SB_CMUX    = 3;
    localparam int SB_TD_EN   = 4;
endpackage

// File: rtl/cal_xfer_fsm.sv
module cal_xfer_fsm
    import cal_pkg::*;
#(
    parameter int AW      = 7,
    parameter int DW      = 8,
    parameter bit CAPTURE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rnw_in,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    input  logic          done,
    input  logic [DW-1:0] rdata_in,
    output logic          req,
    output logic          rnw,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data,
    output logic          busy,
    output logic          cap_valid,
    output logic [DW-1:0] cap_data
);
    xfer_state_t state_q, state_d;
    logic          rnw_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          accept;

    assign accept = (state_q == XF_IDLE) && start;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE: if (start) state_d = XF_WAIT;
            XF_WAIT: if (done)  state_d = XF_IDLE;
            default: state_d = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XF_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end

    generate
        if (CAPTURE) begin : g_dir
            always_ff @(posedge clk) begin
                if (!rst_n)      rnw_q <= 1'b0;
                else if (accept) rnw_q <= rnw_in;
            end
        end else begin : g_wo
            assign rnw_q = 1'b0;
        end
    endgenerate

    always_comb begin
        req       = (state_q == XF_WAIT);
        busy      = req;
        rnw       = rnw_q;
        addr      = addr_q;
        data      = data_q;
        cap_valid = req && done && rnw_q;
        cap_data  = rdata_in;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !done) |=> req); // R12
    AST_PAYLOAD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !done) |=> ($stable(addr) && $stable(data) && $stable(rnw))); // R12
    AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (req && done) |=> !req); // R4
endmodule

// File: rtl/cal_key_fsm.sv
module cal_key_fsm
    import cal_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          on_page,
    input  logic          key_wr,
    input  logic [DW-1:0] key_val,
    output logic          unlocked,
    output logic          enh_on,
    output logic          enh_clr
);
    key_state_t key_q, key_d;
    enh_state_t enh_q, enh_d;
    logic       clr_q, clr_d;

    always_comb begin
        key_d = key_q;
        unique case (key_q)
            KEY_LOCKED: if (on_page && key_wr && key_val == KEY_UNLOCK) key_d = KEY_OPEN;
            KEY_OPEN:   if (!on_page) key_d = KEY_LOCKED;
            default:    key_d = KEY_LOCKED;
        endcase
        if (!on_page) key_d = KEY_LOCKED;
    end

    always_comb begin
        enh_d = enh_q;
        clr_d = 1'b0;
        if (key_wr && key_val == KEY_ENH_OFF) begin
            enh_d = ENH_OFF;
            clr_d = 1'b1;
        end else begin
            unique case (enh_q)
                ENH_OFF: if (key_wr && key_val == KEY_ENH_ON) enh_d = ENH_ON;
                ENH_ON:  enh_d = ENH_ON;
                default: enh_d = ENH_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= KEY_LOCKED;
            enh_q <= ENH_OFF;
            clr_q <= 1'b0;
        end else begin
            key_q <= key_d;
            enh_q <= enh_d;
            clr_q <= clr_d;
        end
    end

    always_comb begin
        unlocked = (key_q == KEY_OPEN);
        enh_on   = (enh_q == ENH_ON);
        enh_clr  = clr_q;
    end

    AST_LOCK_OFFPAGE: assert property (@(posedge clk) disable iff (!rst_n)
        !on_page |=> !unlocked); // R6
    AST_CLEAR_MEANS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        enh_clr |-> !enh_on); // R10
endmodule

// File: rtl/cal_regif.sv
module cal_regif
    import cal_pkg::*;
#(
    parameter int          PAGE_W   = 3,
    parameter int          OFS_W    = 4,
    parameter int          DW       = 8,
    parameter int          EE_AW    = 7,
    parameter int          TD_AW    = 3,
    parameter int          CAL_PAGE = 3,
    parameter int          OFS_BASE = 12,
    parameter logic [7:0]  REV_CODE = 8'h21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] bus_page,
    input  logic [OFS_W-1:0]  bus_ofs,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              ee_req,
    output logic              ee_rnw,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [DW-1:0]     ee_wdata,
    input  logic              ee_done,
    input  logic [DW-1:0]     ee_rdata,
    output logic              td_req,
    output logic [TD_AW-1:0]  td_addr,
    output logic [DW-1:0]     td_data,
    input  logic              td_done,
    output logic              calmux_en,
    output logic              cal_reload,
    output logic              enh_mode,
    output logic              enh_clear
);
    localparam logic [OFS_W-1:0] OFS_DATA = OFS_W'(OFS_BASE);
    localparam logic [OFS_W-1:0] OFS_ADDR = OFS_W'(OFS_BASE + 1);
    localparam logic [OFS_W-1:0] OFS_CTL  = OFS_W'(OFS_BASE + 2);
    localparam logic [OFS_W-1:0] OFS_KEY  = OFS_W'(OFS_BASE + 3);

    logic             on_page;
    logic             wr_data, wr_addr, wr_ctl, wr_key;
    logic [DW-1:0]    data_q;
    logic [EE_AW-1:0] addr_q;
    logic             cmux_q, tden_q, reload_q;
    logic             key_open;
    logic             ee_start, td_start;
    logic             ee_busy, td_busy, ee_cap;
    logic [DW-1:0]    ee_cap_data, td_cap_unused;
    logic             td_rnw_unused, td_cap_v_unused;
    logic [DW-1:0]    status;

    assign on_page = (bus_page == PAGE_W'(CAL_PAGE));
    assign wr_data = bus_wr && on_page && (bus_ofs == OFS_DATA);
    assign wr_addr = bus_wr && on_page && (bus_ofs == OFS_ADDR);
    assign wr_ctl  = bus_wr && on_page && (bus_ofs == OFS_CTL);
    assign wr_key  = bus_wr && on_page && (bus_ofs == OFS_KEY);

    assign ee_start = wr_ctl && bus_wdata[CB_EE_GO] && key_open;
    assign td_start = wr_ctl && bus_wdata[CB_TD_GO];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            addr_q   <= '0;
            cmux_q   <= 1'b0;
            tden_q   <= 1'b0;
            reload_q <= 1'b0;
        end else begin
            if (ee_cap)       data_q <= ee_cap_data;
            else if (wr_data) data_q <= bus_wdata;
            if (wr_addr)      addr_q <= bus_wdata[EE_AW-1:0];
            if (wr_ctl) begin
                cmux_q <= bus_wdata[CB_CMUX];
                tden_q <= bus_wdata[CB_TD_GO];
            end
            reload_q <= wr_ctl && bus_wdata[CB_RELOAD];
        end
    end

    cal_key_fsm #(.DW(DW)) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .on_page  (on_page),
        .key_wr   (wr_key),
        .key_val  (bus_wdata),
        .unlocked (key_open),
        .enh_on   (enh_mode),
        .enh_clr  (enh_clear)
    );

    cal_xfer_fsm #(.AW(EE_AW), .DW(DW), .CAPTURE(1'b1)) u_ee (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ee_start),
        .rnw_in    (bus_wdata[CB_EE_RNW]),
        .addr_in   (addr_q),
        .data_in   (data_q),
        .done      (ee_done),
        .rdata_in  (ee_rdata),
        .req       (ee_req),
        .rnw       (ee_rnw),
        .addr      (ee_addr),
        .data      (ee_wdata),
        .busy      (ee_busy),
        .cap_valid (ee_cap),
        .cap_data  (ee_cap_data)
    );

    cal_xfer_fsm #(.AW(TD_AW), .DW(DW), .CAPTURE(1'b0)) u_td (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (td_start),
        .rnw_in    (1'b0),
        .addr_in   (addr_q[TD_AW-1:0]),
        .data_in   (data_q),
        .done      (td_done),
        .rdata_in  ('0),
        .req       (td_req),
        .rnw       (td_rnw_unused),
        .addr      (td_addr),
        .data      (td_data),
        .busy      (td_busy),
        .cap_valid (td_cap_v_unused),
        .cap_data  (td_cap_unused)
    );

    always_comb begin
        status             = '0;
        status[SB_TD_BUSY] = td_busy;
        status[SB_EE_BUSY] = ee_busy;
        status[SB_CMUX]    = cmux_q;
        status[SB_TD_EN]   = tden_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (on_page) begin
            unique case (bus_ofs)
                OFS_DATA: bus_rdata = data_q;
                OFS_ADDR: bus_rdata = DW'(addr_q);
                OFS_CTL:  bus_rdata = status;
                OFS_KEY:  bus_rdata = REV_CODE;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign calmux_en  = cmux_q;
    assign cal_reload = reload_q;

    AST_EE_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_req) |-> $past(key_open)); // R5
    AST_RELOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_reload && !$past(wr_ctl)) |-> 1'b0); // R9
    AST_BUSY_MATCHES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (on_page && bus_ofs == OFS_CTL) |-> (bus_rdata[SB_EE_BUSY] == ee_req)); // R3
endmodule

// File: tb/cal_regif_tb.sv
module cal_regif_tb;
    localparam logic [7:0] REV = 8'h21;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_page = 3'd3;
    logic [3:0] bus_ofs = 4'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ee_req, ee_rnw;
    logic [6:0] ee_addr;
    logic [7:0] ee_wdata;
    logic       ee_done = 1'b0;
    logic [7:0] ee_rdata = 8'h00;
    logic       td_req;
    logic [2:0] td_addr;
    logic [7:0] td_data;
    logic       td_done = 1'b0;
    logic       calmux_en, cal_reload, enh_mode, enh_clear;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cal_regif #(.REV_CODE(REV)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_page(bus_page), .bus_ofs(bus_ofs),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ee_req(ee_req), .ee_rnw(ee_rnw), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
        .ee_done(ee_done), .ee_rdata(ee_rdata), .td_req(td_req), .td_addr(td_addr),
        .td_data(td_data), .td_done(td_done), .calmux_en(calmux_en),
        .cal_reload(cal_reload), .enh_mode(enh_mode), .enh_clear(enh_clear)
    );

    typedef struct packed {
        logic       wr;
        logic [2:0] pg;
        logic [3:0] ofs;
        logic [7:0] val;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd3, 4'd12, 8'h00, 4'd1},  // R1 data reset
        '{1'b0, 3'd3, 4'd13, 8'h00, 4'd1},  // R1 addr reset
        '{1'b0, 3'd3, 4'd14, 8'h00, 4'd1},  // R1 status reset
        '{1'b1, 3'd3, 4'd12, 8'h5A, 4'd2},  // R2
        '{1'b0, 3'd3, 4'd12, 8'h5A, 4'd2},  // R2
        '{1'b1, 3'd3, 4'd13, 8'hFF, 4'd2},  // R2
        '{1'b0, 3'd3, 4'd13, 8'h7F, 4'd2},  // R2 bit 7 masked
        '{1'b1, 3'd2, 4'd12, 8'h33, 4'd2},  // R2 other page
        '{1'b0, 3'd3, 4'd12, 8'h5A, 4'd2},  // R2 unchanged
        '{1'b0, 3'd3, 4'd15, REV,   4'd11}, // R11 revision
        '{1'b0, 3'd2, 4'd12, 8'h00, 4'd11}, // R11 other page
        '{1'b0, 3'd3, 4'd11, 8'h00, 4'd11}, // R11 other offset
        '{1'b1, 3'd3, 4'd14, 8'h08, 4'd8},  // R8
        '{1'b0, 3'd3, 4'd14, 8'h08, 4'd8},  // R8 status bit 3
        '{1'b1, 3'd3, 4'd14, 8'h00, 4'd8},  // R8
        '{1'b0, 3'd3, 4'd14, 8'h00, 4'd8}   // R8
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] pg, input logic [3:0] ofs, input logic [7:0] d);
        @(negedge clk);
        bus_page = pg; bus_ofs = ofs; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_page = 3'd3;
    endtask

    task automatic rd(input logic [3:0] ofs, output logic [7:0] d);
        bus_page = 3'd3; bus_ofs = ofs;
        #1 d = bus_rdata;
    endtask

    task automatic ee_finish(input logic [7:0] rb);
        @(negedge clk);
        ee_done = 1'b1; ee_rdata = rb;
        @(negedge clk);
        ee_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ee_req", {7'd0, ee_req}, 8'h00);
        chk("R1 enh_mode", {7'd0, enh_mode}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                wr(VEC[i].pg, VEC[i].ofs, VEC[i].val);
            end else begin
                @(negedge clk);
                bus_page = VEC[i].pg; bus_ofs = VEC[i].ofs;
                #1 n_chk++;
                if (bus_rdata !== VEC[i].val) begin
                    n_bad++;
                    $display("FAIL R%0d vector %0d: actual %02h expected %02h",
                             VEC[i].rq, i, bus_rdata, VEC[i].val);
                end
                bus_page = 3'd3;
            end
        end

        // R5: start while locked is ignored
        wr(3'd3, 4'd14, 8'h01);
        chk("R5 locked req", {7'd0, ee_req}, 8'h00);
        rd(4'd14, r); chk("R5 locked status", r, 8'h00);

        // R6 unlock, R3 write start
        wr(3'd3, 4'd15, 8'hA5);
        wr(3'd3, 4'd13, 8'h45);
        wr(3'd3, 4'd12, 8'h3C);
        wr(3'd3, 4'd14, 8'h01);
        chk("R3 req", {7'd0, ee_req}, 8'h01);
        chk("R3 rnw", {7'd0, ee_rnw}, 8'h00);
        chk("R3 addr", {1'b0, ee_addr}, 8'h45);
        chk("R3 wdata", ee_wdata, 8'h3C);
        rd(4'd14, r); chk("R3 status busy", r, 8'h02);
        // R12 payload frozen under host rewrite
        wr(3'd3, 4'd13, 8'h11);
        chk("R12 addr held", {1'b0, ee_addr}, 8'h45);
        chk("R12 req held", {7'd0, ee_req}, 8'h01);
        // R5 start while busy ignored
        wr(3'd3, 4'd14, 8'h03);
        chk("R5 busy rnw", {7'd0, ee_rnw}, 8'h00);
        ee_finish(8'hEE);
        chk("R4 req drop", {7'd0, ee_req}, 8'h00);
        rd(4'd14, r); chk("R4 status idle", r, 8'h00);
        rd(4'd12, r); chk("R4 write keeps data", r, 8'h3C);

        // R4 read completion, R6 unlock persists
        wr(3'd3, 4'd14, 8'h03);
        chk("R6 still open", {7'd0, ee_req}, 8'h01);
        chk("R3 read rnw", {7'd0, ee_rnw}, 8'h01);
        chk("R3 read addr", {1'b0, ee_addr}, 8'h11);
        ee_finish(8'hC9);
        rd(4'd12, r); chk("R4 captured", r, 8'hC9);
        rd(4'd14, r); chk("R4 busy clear", r, 8'h00);

        // R6 leaving page relocks
        @(negedge clk); bus_page = 3'd2;
        @(negedge clk); bus_page = 3'd3;
        wr(3'd3, 4'd14, 8'h01);
        chk("R6 relocked", {7'd0, ee_req}, 8'h00);
        wr(3'd3, 4'd15, 8'hA5);
        wr(3'd3, 4'd14, 8'h01);
        chk("R6 reopened", {7'd0, ee_req}, 8'h01);
        ee_finish(8'h00);

        // R7 trim-DAC
        wr(3'd3, 4'd13, 8'h7D);
        wr(3'd3, 4'd12, 8'h66);
        wr(3'd3, 4'd14, 8'h10);
        chk("R7 req", {7'd0, td_req}, 8'h01);
        chk("R7 addr", {5'd0, td_addr}, 8'h05);
        chk("R7 data", td_data, 8'h66);
        chk("R7 ee untouched", {7'd0, ee_req}, 8'h00);
        rd(4'd14, r); chk("R7 status", r, 8'h11);
        wr(3'd3, 4'd12, 8'h99);
        wr(3'd3, 4'd14, 8'h10);
        chk("R7 busy ignore", td_data, 8'h66);
        @(negedge clk); td_done = 1'b1;
        @(negedge clk); td_done = 1'b0;
        chk("R7 req drop", {7'd0, td_req}, 8'h00);
        rd(4'd14, r); chk("R7 status idle", r, 8'h10);
        rd(4'd12, r); chk("R7 no readback", r, 8'h99);

        // R8 output pin
        wr(3'd3, 4'd14, 8'h08);
        chk("R8 calmux pin", {7'd0, calmux_en}, 8'h01);

        // R9 reload strobe
        wr(3'd3, 4'd14, 8'h04);
        chk("R9 pulse", {7'd0, cal_reload}, 8'h01);
        @(negedge clk);
        chk("R9 single", {7'd0, cal_reload}, 8'h00);

        // R10 enhanced mode
        wr(3'd3, 4'd15, 8'hA6);
        chk("R10 on", {7'd0, enh_mode}, 8'h01);
        chk("R10 no clear", {7'd0, enh_clear}, 8'h00);
        wr(3'd3, 4'd15, 8'hA7);
        chk("R10 off", {7'd0, enh_mode}, 8'h00);
        chk("R10 clear", {7'd0, enh_clear}, 8'h01);
        @(negedge clk);
        chk("R10 clear single", {7'd0, enh_clear}, 8'h00);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule